// File: doc/BRIEF.md
# Prescaled Free-Running Tick Counter

This block keeps a 16-bit up-counter that advances once per prescaler period. The period is picked by a two-bit divide select in a control byte: one, four, eight or sixteen clock cycles per count. The counter wraps from its all-ones value to zero. On each wrap it sets a sticky overflow flag. An interrupt request is driven from that flag whenever the enable bit in the same control byte is set.

Software can load the counter one byte at a time. A write to one byte leaves the other byte as it was, so a full 16-bit value takes two writes. Every load restarts the prescaler phase, so the count always advances a full period after it was written. The divide select can be changed only for a short window after reset. After the window closes, writes to the control byte still update all its other bits but keep the select bits fixed. The flag is cleared by writing a one to it. All inputs are plain single-cycle strobes with no back-pressure: a strobe that is high at a rising clock edge takes effect at that edge.

Top module: `prescaled_ticker`

## Requirements
- R1: Control bits [1:0] select the divide ratio: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16. With ratio N and no load, `count` advances by exactly one every N clock cycles and wraps 0xFFFF to 0x0000.
- R2: A control write at one of the first 64 rising edges after reset release updates all eight bits. A control write at any later edge updates bits [7:2] and keeps bits [1:0] unchanged.
- R3: `ovf_flag` becomes 1 at the edge where the counter steps from 0xFFFF to 0x0000 on its own.
- R4: A flag write with `flag_wbit`=1 clears `ovf_flag`. A flag write with `flag_wbit`=0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R5: A counter write with `cnt_wr_hi`=1 loads `cnt_wdata` into count[15:8] and keeps count[7:0] as it was before the edge.
- R6: A counter write with `cnt_wr_hi`=0 loads `cnt_wdata` into count[7:0] and keeps count[15:8] as it was before the edge.
- R7: While reset is asserted, `count`, `ctl_q` and `ovf_flag` are 0, so the divide ratio is 1 and `ovf_irq` is 0.
- R8: `ovf_irq` is 1 exactly when `ovf_flag` is 1 and control bit 7 (overflow interrupt enable) is 1.
- R9: A counter load, or an accepted change of the divide select, restarts the prescaler phase. With ratio N, the first increment after a load appears N edges after the load edge.
- R10: `count` shows the live count in the cycle after each edge, with both bytes taken from the same register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Counter byte write strobe |
| cnt_wr_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| cnt_wdata | input | 8 | Counter byte write data |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control write data: [1:0] divide select, [7] overflow interrupt enable |
| flag_wr | input | 1 | Flag write strobe |
| flag_wbit | input | 1 | Value written to the overflow flag position (1 clears) |
| count | output | 16 | Live counter value |
| ctl_q | output | 8 | Current control byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Every strobe acts at the rising edge it is sampled on. Its result, whether a loaded byte, a new control value, a wrap into the flag or a cleared flag, is visible one edge later, and the request output follows the flag in the same cycle. The bench drives on falling edges and compares on the next falling edge against an arithmetic model of the requirements. That model counts the prescaler phase from the last load and the edges since reset, so an increment that comes one edge early or late is reported. Each of the four divide ratios gets its own reset, load and wrap run. Each run is checked cycle by cycle over the lock window and across the boundary where the window closes.

// File: rtl/prescaled_ticker_pkg.sv
package prescaled_ticker_pkg;
  localparam int CTL_W       = 8;
  localparam int SEL_LSB     = 0;
  localparam int IRQ_EN_BIT  = 7;
  localparam int RATIO_W     = 5;

  typedef enum logic [1:0] {
    DIV_1  = 2'd0,
    DIV_4  = 2'd1,
    DIV_8  = 2'd2,
    DIV_16 = 2'd3
  } div_sel_e;

  function automatic logic [RATIO_W-1:0] sel_to_ratio(input div_sel_e s);
    case (s)
      DIV_1:   return 5'd1;
      DIV_4:   return 5'd4;
      DIV_8:   return 5'd8;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/ticker_ctrl.sv
module ticker_ctrl
  import prescaled_ticker_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output div_sel_e         div_sel,
  output logic             sel_change
);
  localparam int AGE_W = $clog2(LOCK_CYCLES + 1);

  logic [AGE_W-1:0] age_q;
  logic             locked;
  logic [CTL_W-1:0] ctl_next;

  assign locked = (age_q >= AGE_W'(LOCK_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       age_q <= '0;
    else if (!locked) age_q <= age_q + 1'b1;
  end

  always_comb begin
    ctl_next = ctl_wdata;
    if (locked) ctl_next[SEL_LSB +: 2] = ctl_q[SEL_LSB +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_next;
  end

  assign div_sel    = div_sel_e'(ctl_q[SEL_LSB +: 2]);
  assign sel_change = ctl_wr && (ctl_next[SEL_LSB +: 2] != ctl_q[SEL_LSB +: 2]);
endmodule

// File: rtl/ticker_presc.sv
module ticker_presc
  import prescaled_ticker_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  div_sel_e div_sel,
  input  logic     restart,
  output logic     tick
);
  logic [PH_W-1:0]    phase_q;
  logic [RATIO_W-1:0] ratio;
  logic               at_end;

  assign ratio  = sel_to_ratio(div_sel);
  assign at_end = (RATIO_W'(phase_q) == ratio - 1'b1);
  assign tick   = at_end && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (restart || at_end) phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/ticker_count.sv
module ticker_count #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld,
  input  logic              ld_hi,
  input  logic [BYTE_W-1:0] ld_data,
  output logic [CNT_W-1:0]  count,
  output logic              wrap
);
  localparam int HI_W = CNT_W - BYTE_W;

  assign wrap = tick && !ld && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (ld) begin
      if (ld_hi) count <= {ld_data[HI_W-1:0], count[BYTE_W-1:0]};
      else       count <= {count[CNT_W-1:BYTE_W], ld_data};
    end
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/ticker_flag.sv
module ticker_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_wr,
  input  logic clr_bit,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (set)              flag <= 1'b1;
    else if (clr_wr && clr_bit) flag <= 1'b0;
  end

  assign irq = flag && irq_en;
endmodule

// File: rtl/prescaled_ticker.sv
module prescaled_ticker
  import prescaled_ticker_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int PH_W        = 4,
  parameter int LOCK_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr,
  input  logic              cnt_wr_hi,
  input  logic [BYTE_W-1:0] cnt_wdata,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              flag_wr,
  input  logic              flag_wbit,
  output logic [CNT_W-1:0]  count,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              ovf_flag,
  output logic              ovf_irq
);
  div_sel_e div_sel;
  logic     sel_change;
  logic     tick;
  logic     wrap;

  ticker_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .div_sel(div_sel), .sel_change(sel_change)
  );

  ticker_presc #(.PH_W(PH_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
    .restart(cnt_wr || sel_change), .tick(tick)
  );

  ticker_count #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(cnt_wr), .ld_hi(cnt_wr_hi),
    .ld_data(cnt_wdata), .count(count), .wrap(wrap)
  );

  ticker_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(wrap), .clr_wr(flag_wr), .clr_bit(flag_wbit),
    .irq_en(ctl_q[IRQ_EN_BIT]), .flag(ovf_flag), .irq(ovf_irq)
  );
endmodule

// File: rtl/prescaled_ticker_chk.sv
module prescaled_ticker_chk #(
  parameter int CNT_W       = 16,
  parameter int LOCK_CYCLES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic             cnt_wr_hi,
  input logic             flag_wr,
  input logic             flag_wbit,
  input logic [CNT_W-1:0] count,
  input logic [7:0]       ctl_q,
  input logic             ovf_flag,
  input logic             ovf_irq
);
  localparam int AGE_W = $clog2(LOCK_CYCLES + 1);
  logic [AGE_W-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age < AGE_W'(LOCK_CYCLES)) age <= age + 1'b1;
  end

  assert_sel_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= AGE_W'(LOCK_CYCLES)) |=> $stable(ctl_q[1:0]));

  assert_wrap_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && count == {CNT_W{1'b1}}) |=> (count != '0 || ovf_flag));

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(flag_wr && flag_wbit)) |=> ovf_flag);

  assert_hi_keeps_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && cnt_wr_hi) |=> (count[7:0] == $past(count[7:0])));

  assert_lo_keeps_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !cnt_wr_hi) |=> (count[CNT_W-1:8] == $past(count[CNT_W-1:8])));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq == (ovf_flag && ctl_q[7]));

  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count == $past(count) || count == $past(count) + 1'b1));
endmodule

bind prescaled_ticker prescaled_ticker_chk #(.CNT_W(CNT_W), .LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wr_hi(cnt_wr_hi),
  .flag_wr(flag_wr), .flag_wbit(flag_wbit), .count(count), .ctl_q(ctl_q),
  .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
);

// File: tb/prescaled_ticker_tb.sv
module prescaled_ticker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_wr = 1'b0, cnt_wr_hi = 1'b0, ctl_wr = 1'b0;
  logic        flag_wr = 1'b0, flag_wbit = 1'b0;
  logic [7:0]  cnt_wdata = '0, ctl_wdata = '0;
  logic [15:0] count;
  logic [7:0]  ctl_q;
  logic        ovf_flag, ovf_irq;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_cnt;
  logic [7:0]  m_ctl;
  logic        m_flag;
  int          m_ph, m_age;

  always #2 clk = ~clk;

  prescaled_ticker u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wr_hi(cnt_wr_hi),
    .cnt_wdata(cnt_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .flag_wr(flag_wr), .flag_wbit(flag_wbit), .count(count), .ctl_q(ctl_q),
    .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  function automatic int ratio_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : (s == 2'd2) ? 8 : 16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1 R9 R10 count", {16'h0, count}, {16'h0, m_cnt});
    chk("R3 flag", {31'h0, ovf_flag}, {31'h0, m_flag});
    chk("R8 irq", {31'h0, ovf_irq}, {31'h0, m_flag & m_ctl[7]});
    chk("R2 ctl", {24'h0, ctl_q}, {24'h0, m_ctl});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    m_cnt = '0; m_ctl = '0; m_flag = 1'b0; m_ph = 0; m_age = 0;
    chk("R7 reset count", {16'h0, count}, 32'h0);
    chk("R7 reset flag/irq", {30'h0, ovf_flag, ovf_irq}, 32'h0);
    chk("R7 reset ctl", {24'h0, ctl_q}, 32'h0);
    rst_n = 1'b1;
  endtask

  // One clock: drive strobes, advance the requirement model, check.
  task automatic cyc(input logic cw, input logic hi, input logic [7:0] d,
                     input logic kw, input logic [7:0] kd,
                     input logic fw, input logic fb);
    logic [7:0] new_ctl;
    logic       restart, tick, wrap;
    int         div;
    cnt_wr = cw; cnt_wr_hi = hi; cnt_wdata = d;
    ctl_wr = kw; ctl_wdata = kd; flag_wr = fw; flag_wbit = fb;
    @(posedge clk);
    div     = ratio_of(m_ctl[1:0]);
    new_ctl = m_ctl;
    if (kw) new_ctl = (m_age < 64) ? kd : {kd[7:2], m_ctl[1:0]};
    restart = cw || (new_ctl[1:0] != m_ctl[1:0]);
    tick    = (m_ph == div - 1) && !restart;
    wrap    = tick && !cw && (m_cnt == 16'hFFFF);
    m_ph    = (restart || m_ph == div - 1) ? 0 : m_ph + 1;
    if (cw) m_cnt = hi ? {d, m_cnt[7:0]} : {m_cnt[15:8], d};
    else if (tick) m_cnt = m_cnt + 16'd1;
    if (wrap) m_flag = 1'b1;
    else if (fw && fb) m_flag = 1'b0;
    m_ctl = new_ctl;
    if (m_age < 64) m_age++;
    @(negedge clk);
    cnt_wr = 1'b0; ctl_wr = 1'b0; flag_wr = 1'b0;
    check_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 8'h00, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      int div;
      do_reset();
      div = ratio_of(2'(s));
      // R1: select written inside the window; bit 7 enables the request
      cyc(0, 0, 8'h00, 1, {1'b1, 5'h0, 2'(s)}, 0, 0);
      chk("R1 sel accepted", {30'h0, ctl_q[1:0]}, s);
      // R5 then R6: byte loads keep the other byte
      cyc(1, 1, 8'hFF, 0, 8'h00, 0, 0);
      cyc(1, 0, 8'hF0, 0, 8'h00, 0, 0);
      chk("R5 R6 load", {16'h0, count}, 32'hFFF0);
      // R9: no increment before div edges after load
      if (div > 1) begin
        idle(div - 1);
        chk("R9 held before period", {16'h0, count}, 32'hFFF0);
        idle(1);
        chk("R9 first step", {16'h0, count}, 32'hFFF1);
      end
      // R3/R8: run across the wrap
      idle(17 * div);
      chk("R3 wrapped flag", {31'h0, ovf_flag}, 32'h1);
      chk("R8 irq high", {31'h0, ovf_irq}, 32'h1);
      // R4: write 0 keeps, write 1 clears
      cyc(0, 0, 8'h00, 0, 8'h00, 1, 0);
      chk("R4 zero keeps", {31'h0, ovf_flag}, 32'h1);
      cyc(0, 0, 8'h00, 0, 8'h00, 1, 1);
      chk("R4 one clears", {31'h0, ovf_flag}, 32'h0);
      // R9: load mid-phase then run
      idle(1);
      cyc(1, 0, 8'h55, 0, 8'h00, 0, 0);
      idle(3 * div);
      if (s == 0) begin
        // R4: wrap beats a clear in the same cycle
        cyc(1, 1, 8'hFF, 0, 8'h00, 0, 0);
        cyc(1, 0, 8'hFF, 0, 8'h00, 0, 0);
        cyc(0, 0, 8'h00, 0, 8'h00, 1, 1);
        chk("R4 set wins", {31'h0, ovf_flag}, 32'h1);
        // R8: disable the request while flag is up
        cyc(0, 0, 8'h00, 1, 8'h00, 0, 0);
        chk("R8 irq gated off", {31'h0, ovf_irq}, 32'h0);
      end
      // R2: close the window, then try to change select
      idle(70);
      cyc(0, 0, 8'h00, 1, {1'b0, 5'h0A, 2'(s ^ 3)}, 0, 0);
      chk("R2 sel kept", {30'h0, ctl_q[1:0]}, s);
      chk("R2 upper bits updated", {24'h0, ctl_q[7:2]}, {1'b0, 5'h0A});
      cyc(1, 0, 8'h00, 0, 8'h00, 0, 0);
      idle(3 * div);
      chk("R2 rate unchanged", {16'h0, count[7:0]}, 32'h3);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule